// File: doc/BRIEF.md
# SD/MMC Host Interrupt Status and Mask Unit

This unit gathers single-cycle event pulses from the command and data engines of an SD/MMC host controller. Each pulse latches a bit in a raw status word, which holds it until software writes a 1 to that bit. A software-programmed mask selects which latched events are reported. The masked word drives one interrupt line, and a global enable bit in the control word gates that line.

Software reaches four 32-bit words through a simple register port. The control word holds the enable and a soft-reset command. The other three are the mask, the masked status and the raw status. A combined error flag tells the transfer engines that any error-class event has latched.

In boot and voltage-switch modes, bits 8, 9 and 10 take other meanings: acknowledge received, boot start and voltage change done. They still use the same storage and the same clear rule, so the unit needs no mode input.

Top module: `sdhost_irq_unit`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and `err_any` is low.
- R2: An event pulse on an implemented bit sets that raw status bit, read at offset 0x38, on the next clock edge, whatever the mask holds. The implemented bits are 1 to 16, 30 and 31. Pulses on bits 0 and 17 to 29 are ignored, and those bits always read 0.
- R3: The mask at offset 0x30 stores only the implemented bits. The masked status at offset 0x34 reads as raw status AND mask.
- R4: Writing to offset 0x38 or 0x34 clears every raw bit whose write-data bit is 1. Raw bits whose write-data bit is 0 keep their value.
- R5: `irq` is high exactly when control bit 4 (interrupt enable) is 1 and the masked status is non-zero.
- R6: When an event pulse and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R7: Writing control (offset 0x00) with bit 0 set clears all raw bits. This clear wins over events arriving in the same cycle. Bit 0 reads back as 0, and the same write still loads bit 4.
- R8: `err_any` is the OR of raw bits 1, 6, 7, 8, 11, 12, 13 and 15.
- R9: Reads from any other offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| evt | input | 32 | Event pulses, one per status bit |
| irq | output | 1 | Interrupt line |
| err_any | output | 1 | Error summary of the raw status |

## Verification
Directed sequences come first. Single events are tried with the mask both open and closed, which separates latching from reporting. Same-cycle event-plus-clear and event-plus-soft-reset pairs fix the priority order. Events and clears on reserved bits check that only implemented bits can be set. Error and non-error bits are set one at a time, which shows whether `err_any` decodes the right group. A long stretch of pseudo-random writes, addresses and event words follows, checked against a behavioural model on every cycle. This mixes enable, mask and clear interactions that the directed cases do not reach.

// File: rtl/sdhost_irq_unit.sv
module sdhost_irq_unit #(
  parameter int          ADDR_W    = 8,
  parameter int          EN_BIT    = 4,
  parameter int          SRST_BIT  = 0,
  parameter logic [31:0] IMPL_MASK = 32'hC001_FFFE,
  parameter logic [31:0] ERR_MASK  = 32'h0000_B9C2,
  parameter int          CTRL_OFS  = 'h00,
  parameter int          MASK_OFS  = 'h30,
  parameter int          MSTAT_OFS = 'h34,
  parameter int          RAW_OFS   = 'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [31:0]       evt,
  output logic              irq,
  output logic              err_any
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(MSTAT_OFS);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(RAW_OFS);

  logic [31:0] raw_q, mask_q;
  logic        en_q;

  wire         wr_ctrl  = wr_en && (addr == A_CTRL);
  wire         soft_rst = wr_ctrl && wdata[SRST_BIT];
  wire [31:0]  clr_bits = (wr_en && (addr == A_RAW || addr == A_MSTAT)) ? wdata : '0;
  wire [31:0]  ev_bits  = evt & IMPL_MASK;
  wire [31:0]  masked   = raw_q & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= wdata[EN_BIT];
      if (wr_en && addr == A_MASK) mask_q <= wdata & IMPL_MASK;
      raw_q <= soft_rst ? '0 : ((raw_q & ~clr_bits) | ev_bits);
    end
  end

  assign irq     = en_q && (masked != '0);
  assign err_any = (raw_q & ERR_MASK) != '0;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[EN_BIT] = en_q;
      A_MASK:  rdata = mask_q;
      A_MSTAT: rdata = masked;
      A_RAW:   rdata = raw_q;
      default: rdata = '0;
    endcase
  end
endmodule

module sdhost_irq_unit_chk #(
  parameter int          ADDR_W    = 8,
  parameter int          EN_BIT    = 4,
  parameter int          SRST_BIT  = 0,
  parameter logic [31:0] IMPL_MASK = 32'hC001_FFFE,
  parameter int          CTRL_OFS  = 'h00,
  parameter int          MSTAT_OFS = 'h34,
  parameter int          RAW_OFS   = 'h38
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       evt,
  input logic              irq,
  input logic [31:0]       raw_q
);
  wire        srst_w = wr_en && addr == ADDR_W'(CTRL_OFS) && wdata[SRST_BIT];
  wire        dis_w  = wr_en && addr == ADDR_W'(CTRL_OFS) && !wdata[EN_BIT];
  wire        clr_w  = wr_en && (addr == ADDR_W'(RAW_OFS) || addr == ADDR_W'(MSTAT_OFS));
  wire [31:0] ev_c   = evt & IMPL_MASK;

  p_evt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_w && ev_c != '0) |=> ((raw_q & $past(ev_c)) == $past(ev_c)));
  p_srst_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    srst_w |=> (raw_q == '0));
  p_gate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dis_w |=> !irq);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q & ~IMPL_MASK) == '0);
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && ev_c == '0) |=> ((raw_q & $past(wdata)) == '0));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ev_c == '0) |=> $stable(raw_q));
endmodule

bind sdhost_irq_unit sdhost_irq_unit_chk #(
  .ADDR_W(ADDR_W), .EN_BIT(EN_BIT), .SRST_BIT(SRST_BIT), .IMPL_MASK(IMPL_MASK),
  .CTRL_OFS(CTRL_OFS), .MSTAT_OFS(MSTAT_OFS), .RAW_OFS(RAW_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .evt(evt), .irq(irq), .raw_q(raw_q)
);

// File: tb/sdhost_irq_unit_bench.sv
module sdhost_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] evt = '0;
  logic [31:0] rdata;
  logic        irq, err_any;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  localparam logic [31:0] IMPL = 32'hC001_FFFE;
  localparam logic [31:0] ERRB = 32'h0000_B9C2;

  logic [31:0] m_raw = '0, m_mask = '0;
  logic        m_en = 1'b0;

  always #4 clk = ~clk;

  sdhost_irq_unit u_sdhost_irq_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt(evt), .irq(irq), .err_any(err_any)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00:   return {27'd0, m_en, 4'd0};
      8'h30:   return m_mask;
      8'h34:   return m_raw & m_mask;
      8'h38:   return m_raw;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00:   return "R7 ctrl read";
      8'h30:   return "R3 mask read";
      8'h34:   return "R3 masked read";
      8'h38:   return "R2 raw read";
      default: return "R9 unmapped read";
    endcase
  endfunction

  task automatic compare_all();
    chk(tag_of(addr), rdata, exp_rd(addr));
    chk("R5 irq", {31'd0, irq}, {31'd0, m_en && ((m_raw & m_mask) != 0)});
    chk("R8 err_any", {31'd0, err_any}, {31'd0, (m_raw & ERRB) != 0});
  endtask

  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [31:0] e);
    logic [31:0] clr;
    wr_en = w; addr = a; wdata = d; evt = e;
    @(posedge clk);
    clr = (w && (a == 8'h34 || a == 8'h38)) ? d : 32'd0;
    if (w && a == 8'h30) m_mask = d & IMPL;
    if (w && a == 8'h00) m_en = d[4];
    if (w && a == 8'h00 && d[0]) m_raw = '0;
    else m_raw = (m_raw & ~clr) | (e & IMPL);
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
    compare_all();
  endtask

  task automatic peek(input logic [7:0] a, input string tag, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    peek(8'h00, "R1 ctrl reset", 32'd0);
    peek(8'h30, "R1 mask reset", 32'd0);
    peek(8'h38, "R1 raw reset", 32'd0);
    chk("R1 irq reset", {31'd0, irq}, 32'd0);
    chk("R1 err reset", {31'd0, err_any}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: latch with mask closed, reserved bits ignored
    cyc(0, 8'h38, 0, 32'h0000_0004);
    chk("R2 latch masked-off", rdata, 32'h0000_0004);
    cyc(0, 8'h38, 0, 32'h3FFE_0001);
    chk("R2 reserved ignored", rdata, 32'h0000_0004);
    // R3: mask stores implemented bits only
    cyc(1, 8'h30, 32'hFFFF_FFFF, 0);
    chk("R3 mask impl only", rdata, IMPL);
    cyc(1, 8'h30, 32'h0000_000C, 0);
    peek(8'h34, "R3 masked", 32'h0000_0004);
    // R5: gate
    chk("R5 irq gated off", {31'd0, irq}, 32'd0);
    cyc(1, 8'h00, 32'h10, 0);
    chk("R5 irq on", {31'd0, irq}, 32'd1);
    // R4: W1C through raw and masked offsets
    cyc(0, 8'h38, 0, 32'hC001_0008);
    cyc(1, 8'h38, 32'h0000_0004, 0);
    chk("R4 w1c raw", rdata, 32'hC001_0008);
    cyc(1, 8'h34, 32'h4000_0000, 0);
    peek(8'h38, "R4 w1c via masked", 32'h8001_0008);
    // R6: event wins
    cyc(1, 8'h38, 32'h0001_0000, 32'h0001_0000);
    chk("R6 event wins", rdata, 32'h8001_0008);
    // R8: error group
    cyc(1, 8'h38, 32'hFFFF_FFFF, 0);
    chk("R8 err clear", {31'd0, err_any}, 32'd0);
    cyc(0, 8'h38, 0, 32'h0000_0400);
    chk("R8 non-error bit", {31'd0, err_any}, 32'd0);
    for (int b = 1; b <= 16; b++) begin
      cyc(1, 8'h38, 32'hFFFF_FFFF, 0);
      cyc(0, 8'h38, 0, 32'd1 << b);
    end
    // R9: unmapped
    cyc(1, 8'h3C, 32'hFFFF_FFFF, 0);
    cyc(1, 8'h20, 32'hFFFF_FFFF, 0);
    peek(8'h30, "R9 mask untouched", 32'h0000_000C);
    // R7: soft reset wins over events
    cyc(0, 8'h38, 0, 32'h0000_FFFE);
    cyc(1, 8'h00, 32'h11, 32'h0000_00F0);
    chk("R7 soft reset ctrl", rdata, 32'h10);
    peek(8'h38, "R7 soft reset raw", 32'd0);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      logic [7:0]  a;
      logic [31:0] d = $urandom;
      case (r[2:0])
        3'd0: a = 8'h00;
        3'd1: a = 8'h30;
        3'd2, 3'd3: a = 8'h34;
        3'd4, 3'd5: a = 8'h38;
        default: a = 8'h40;
      endcase
      if (a == 8'h00 && r[7:3] != 0) d[0] = 1'b0;
      cyc(r[9:8] == 2'b00, a, d, r[12] ? $urandom : 32'd0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule